// File: doc/BRIEF.md
# Parallel-Port Sample Streamer

This block is a synchronous slave on an 8-bit, EPP-style parallel link coming from a USB bridge. It runs on the bridge-side clock. The host sends command bytes through address-strobe writes. These bytes start or stop the converter side, pick an analog channel with an optional override, and arm sample readout. Once readout is armed, each data-strobe read returns one byte of a 16-bit sample taken from a first-word-fall-through FIFO. The high byte comes first and the low byte follows on the next read.

The block controls the link handshake. It raises `wait_o` once a strobe has been serviced and holds it until the host releases the strobe. It drives the bus output enable and issues a single-cycle FIFO pop. It also holds the converter-side reset and the channel-select outputs. Both strobes are assumed to be synchronous to `clk`. If both strobes are low at once, the address strobe takes priority.

Top module: `pss_streamer`

## Requirements
- R1: An address-strobe cycle with `dir_to_host` = 0 loads `bus_i` as a command byte. Bits 3:0 hold the command code, bits 6:4 hold the channel number, and bit 7 holds the override flag. Codes 4 to 15 leave every output unchanged.
- R2: Code 0 (stop) drives `adc_hold` high and disarms sample readout.
- R3: Code 1 (start) drives `adc_hold` low and disarms readout. It also loads `mux_chan` and `mux_override` from the same byte.
- R4: Code 2 (fetch) arms sample readout only if `adc_hold` is already low. Otherwise it has no effect.
- R5: Code 3 (select channel) loads `mux_chan` and `mux_override` and changes nothing else. A pending low byte survives it.
- R6: While readout is armed, a data read with `dir_to_host` = 1 pops exactly one FIFO word and returns bits 15:8. The next data read returns bits 7:0 of the same word without popping.
- R7: While `adc_hold` is high, the output byte, the latched low byte and the high/low phase are cleared. The first armed read after a restart returns the high byte of a fresh word.
- R8: The following are dummy cycles. An address read returns 0x00. A data read while readout is disarmed returns 0x00 without popping. A data write is completed and has no effect.
- R9: `wait_o` goes high on the clock edge that services a strobe. It stays high while that strobe is low and drops on the edge after both strobes are high.
- R10: `bus_oe` is high only while `wait_o` is high for a read cycle and `dir_to_host` is 1.
- R11: An armed high-byte read with `fifo_valid` low stalls: `wait_o` stays low and nothing is popped until valid data appears.
- R12: After reset: `adc_hold` = 1, `wait_o` = 0, `bus_oe` = 0, `fifo_rd` = 0, `mux_chan` = 0, `mux_override` = 0, and readout is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-side clock |
| rst | input | 1 | Synchronous active-high reset |
| astb_n | input | 1 | Address strobe, active low |
| dstb_n | input | 1 | Data strobe, active low |
| dir_to_host | input | 1 | 1 = read toward the host, 0 = write from the host |
| bus_i | input | 8 | Byte received from the bus |
| bus_o | output | 8 | Byte presented to the bus |
| bus_oe | output | 1 | Tri-state enable for `bus_o` |
| wait_o | output | 1 | Handshake: cycle serviced |
| fifo_rd | output | 1 | One-cycle pop of the FIFO head |
| fifo_valid | input | 1 | FIFO head holds a valid word |
| fifo_data | input | 16 | FIFO head word |
| adc_hold | output | 1 | Holds the converter side in reset when high |
| mux_chan | output | 3 | Selected analog channel |
| mux_override | output | 1 | Channel override flag |

## Verification
The embedded assertions check invariants on every cycle:
- `wait_o` never drops while a strobe is still low.
- A pop is never repeated on consecutive cycles and never happens while a low byte is pending.
- Readout is never armed while the converter is held.
- The byte path is cleared one cycle after a stop.

Other behaviour can only be shown by the bench's scenarios, because it depends on the host's command order and the FIFO contents:
- the exact byte order across pops;
- the low byte surviving a channel change;
- fetch being refused while stopped;
- start disarming readout;
- the stall with an empty FIFO.

// File: rtl/pss_pkg.sv
package pss_pkg;

  // Handshake state of the link slave
  typedef enum logic [0:0] {
    PS_READY = 1'b0,
    PS_HELD  = 1'b1
  } link_state_t;

  // Command codes carried in the low field of a command byte
  localparam int CMD_STOP   = 0;
  localparam int CMD_START  = 1;
  localparam int CMD_FETCH  = 2;
  localparam int CMD_SELECT = 3;

endpackage

// File: rtl/pss_cmd_regs.sv
module pss_cmd_regs #(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 4,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_load,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic              hold_o,
  output logic              getting_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic              ovr_o
);
  import pss_pkg::*;

  localparam int CH_LO   = CODE_W;
  localparam int CH_HI   = CODE_W + CHAN_W - 1;
  localparam int OVR_BIT = BYTE_W - 1;

  logic [CODE_W-1:0] code;
  logic              hold_q, getting_q, ovr_q;
  logic [CHAN_W-1:0] chan_q;

  assign code = cmd_byte[CODE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= 1'b1;
      getting_q <= 1'b0;
      chan_q    <= '0;
      ovr_q     <= 1'b0;
    end else if (cmd_load) begin
      case (code)
        CODE_W'(CMD_STOP): begin
          hold_q    <= 1'b1;
          getting_q <= 1'b0;
        end
        CODE_W'(CMD_START): begin
          hold_q    <= 1'b0;
          getting_q <= 1'b0;
          chan_q    <= cmd_byte[CH_HI:CH_LO];
          ovr_q     <= cmd_byte[OVR_BIT];
        end
        CODE_W'(CMD_FETCH): begin
          getting_q <= !hold_q;
        end
        CODE_W'(CMD_SELECT): begin
          chan_q <= cmd_byte[CH_HI:CH_LO];
          ovr_q  <= cmd_byte[OVR_BIT];
        end
        default: ;
      endcase
    end
  end

  assign hold_o    = hold_q;
  assign getting_o = getting_q;
  assign chan_o    = chan_q;
  assign ovr_o     = ovr_q;

  // R4: readout is never armed while the converter is held
  p_armed_needs_run_r4: assert property (@(posedge clk) disable iff (rst)
    getting_q |-> !hold_q);

  // R2: a stop command leaves the converter held and readout disarmed
  p_stop_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_load && code == CODE_W'(CMD_STOP)) |=> (hold_q && !getting_q));

endmodule

// File: rtl/pss_link_fsm.sv
module pss_link_fsm (
  input  logic clk,
  input  logic rst,
  input  logic astb_n,
  input  logic dstb_n,
  input  logic dir_to_host,
  input  logic getting,
  input  logic phase_lsb,
  input  logic fifo_valid,
  output logic cmd_load,
  output logic pop_msb,
  output logic send_lsb,
  output logic dummy_rd,
  output logic wait_o,
  output logic oe_o
);
  import pss_pkg::*;

  link_state_t state_q;
  logic        wait_q, oe_q, serve;

  always_comb begin
    cmd_load = 1'b0;
    pop_msb  = 1'b0;
    send_lsb = 1'b0;
    dummy_rd = 1'b0;
    serve    = 1'b0;
    if (state_q == PS_READY) begin
      if (!astb_n) begin
        serve = 1'b1;
        if (dir_to_host) dummy_rd = 1'b1;
        else             cmd_load = 1'b1;
      end else if (!dstb_n) begin
        if (!dir_to_host) begin
          serve = 1'b1;
        end else if (!getting) begin
          serve    = 1'b1;
          dummy_rd = 1'b1;
        end else if (phase_lsb) begin
          serve    = 1'b1;
          send_lsb = 1'b1;
        end else if (fifo_valid) begin
          serve   = 1'b1;
          pop_msb = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_READY;
      wait_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        PS_READY: if (serve) begin
          state_q <= PS_HELD;
          wait_q  <= 1'b1;
          oe_q    <= dir_to_host;
        end
        PS_HELD: if (astb_n && dstb_n) begin
          state_q <= PS_READY;
          wait_q  <= 1'b0;
          oe_q    <= 1'b0;
        end
        default: state_q <= PS_READY;
      endcase
    end
  end

  assign wait_o = wait_q;
  assign oe_o   = oe_q;

  // R9: wait stays up while any strobe is still low
  p_wait_held_r9: assert property (@(posedge clk) disable iff (rst)
    (wait_q && !(astb_n && dstb_n)) |=> wait_q);

  // R6: one pop per strobe, never on back-to-back cycles
  p_single_pop_r6: assert property (@(posedge clk) disable iff (rst)
    pop_msb |=> !pop_msb);

  // R10: the output enable only rises together with wait
  p_oe_with_wait_r10: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> wait_q);

endmodule

// File: rtl/pss_byte_splitter.sv
module pss_byte_splitter #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                running,
  input  logic                pop_msb,
  input  logic                send_lsb,
  input  logic                dummy_rd,
  input  logic [2*BYTE_W-1:0] fifo_data,
  output logic [BYTE_W-1:0]   dout_o,
  output logic                phase_o
);
  logic [BYTE_W-1:0] dout_q, lsb_q;
  logic              phase_q;

  always_ff @(posedge clk) begin
    if (rst || !running) begin
      dout_q  <= '0;
      lsb_q   <= '0;
      phase_q <= 1'b0;
    end else if (pop_msb) begin
      dout_q  <= fifo_data[2*BYTE_W-1:BYTE_W];
      lsb_q   <= fifo_data[BYTE_W-1:0];
      phase_q <= 1'b1;
    end else if (send_lsb) begin
      dout_q  <= lsb_q;
      phase_q <= 1'b0;
    end else if (dummy_rd) begin
      dout_q  <= '0;
    end
  end

  assign dout_o  = dout_q;
  assign phase_o = phase_q;

  // R7: stopping clears the whole byte path on the next edge
  p_stop_clears_r7: assert property (@(posedge clk) disable iff (rst)
    !running |=> (dout_q == '0 && lsb_q == '0 && !phase_q));

  // R6: no fresh pop while a low byte is still pending
  p_no_pop_pending_r6: assert property (@(posedge clk) disable iff (rst)
    phase_q |-> !pop_msb);

  // R6: a pop always leaves the low byte pending
  p_pop_sets_phase_r6: assert property (@(posedge clk) disable iff (rst)
    pop_msb |=> phase_q);

endmodule

// File: rtl/pss_streamer.sv
module pss_streamer #(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 4,
  parameter int CHAN_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                astb_n,
  input  logic                dstb_n,
  input  logic                dir_to_host,
  input  logic [BYTE_W-1:0]   bus_i,
  output logic [BYTE_W-1:0]   bus_o,
  output logic                bus_oe,
  output logic                wait_o,
  output logic                fifo_rd,
  input  logic                fifo_valid,
  input  logic [2*BYTE_W-1:0] fifo_data,
  output logic                adc_hold,
  output logic [CHAN_W-1:0]   mux_chan,
  output logic                mux_override
);
  logic hold, getting, phase_lsb;
  logic cmd_load, pop_msb, send_lsb, dummy_rd, oe_q;

  pss_cmd_regs #(.BYTE_W(BYTE_W), .CODE_W(CODE_W), .CHAN_W(CHAN_W)) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .cmd_load  (cmd_load),
    .cmd_byte  (bus_i),
    .hold_o    (hold),
    .getting_o (getting),
    .chan_o    (mux_chan),
    .ovr_o     (mux_override)
  );

  pss_link_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .astb_n      (astb_n),
    .dstb_n      (dstb_n),
    .dir_to_host (dir_to_host),
    .getting     (getting),
    .phase_lsb   (phase_lsb),
    .fifo_valid  (fifo_valid),
    .cmd_load    (cmd_load),
    .pop_msb     (pop_msb),
    .send_lsb    (send_lsb),
    .dummy_rd    (dummy_rd),
    .wait_o      (wait_o),
    .oe_o        (oe_q)
  );

  pss_byte_splitter #(.BYTE_W(BYTE_W)) u_split (
    .clk       (clk),
    .rst       (rst),
    .running   (!hold),
    .pop_msb   (pop_msb),
    .send_lsb  (send_lsb),
    .dummy_rd  (dummy_rd),
    .fifo_data (fifo_data),
    .dout_o    (bus_o),
    .phase_o   (phase_lsb)
  );

  assign adc_hold = hold;
  assign fifo_rd  = pop_msb;
  assign bus_oe   = oe_q & dir_to_host;

  // R11: a pop only happens with valid data at the FIFO head
  p_pop_valid_r11: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> fifo_valid);

endmodule

// File: tb/pss_streamer_test.sv
`timescale 1ns/1ps
module pss_streamer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        astb_n = 1'b1, dstb_n = 1'b1, dir_to_host = 1'b0;
  logic [7:0]  bus_i = 8'h00;
  logic [7:0]  bus_o;
  logic        bus_oe, wait_o, fifo_rd, fifo_valid, adc_hold, mux_override;
  logic [15:0] fifo_data;
  logic [2:0]  mux_chan;

  always #2.5 clk = ~clk;

  // FIFO model: first-word-fall-through
  logic [15:0] fmem [8];
  int rd_idx = 0;
  int avail  = 4;
  assign fifo_data  = fmem[rd_idx[2:0]];
  assign fifo_valid = rd_idx < avail;
  always @(posedge clk) if (!rst && fifo_rd) rd_idx <= rd_idx + 1;

  pss_streamer uut (
    .clk(clk), .rst(rst), .astb_n(astb_n), .dstb_n(dstb_n),
    .dir_to_host(dir_to_host), .bus_i(bus_i), .bus_o(bus_o),
    .bus_oe(bus_oe), .wait_o(wait_o), .fifo_rd(fifo_rd),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .adc_hold(adc_hold),
    .mux_chan(mux_chan), .mux_override(mux_override)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // op: 0 address write, 1 address read, 2 data write, 3 data read
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] din;
    logic [7:0] exp;
    logic       hold;
    logic       ovr;
    logic [2:0] chan;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'hD1, 8'h00, 1'b0, 1'b1, 3'd5, 4'd3},  // R3 start, ch5, override
    '{2'd3, 8'h00, 8'h00, 1'b0, 1'b1, 3'd5, 4'd8},  // R8 read while disarmed
    '{2'd0, 8'h02, 8'h00, 1'b0, 1'b1, 3'd5, 4'd4},  // R4 fetch while running
    '{2'd3, 8'h00, 8'hA1, 1'b0, 1'b1, 3'd5, 4'd6},  // R6 high byte
    '{2'd3, 8'h00, 8'hB2, 1'b0, 1'b1, 3'd5, 4'd6},  // R6 low byte
    '{2'd1, 8'h00, 8'h00, 1'b0, 1'b1, 3'd5, 4'd8},  // R8 address read
    '{2'd2, 8'h55, 8'h00, 1'b0, 1'b1, 3'd5, 4'd8},  // R8 data write ignored
    '{2'd3, 8'h00, 8'hC3, 1'b0, 1'b1, 3'd5, 4'd6},  // R6
    '{2'd0, 8'h63, 8'h00, 1'b0, 1'b0, 3'd6, 4'd5},  // R5 select ch6
    '{2'd3, 8'h00, 8'hD4, 1'b0, 1'b0, 3'd6, 4'd5},  // R5 low byte survives
    '{2'd3, 8'h00, 8'h0F, 1'b0, 1'b0, 3'd6, 4'd6},  // R6 low byte 0E pending
    '{2'd0, 8'h00, 8'h00, 1'b1, 1'b0, 3'd6, 4'd2},  // R2 stop
    '{2'd3, 8'h00, 8'h00, 1'b1, 1'b0, 3'd6, 4'd7},  // R7 pending byte cleared
    '{2'd0, 8'h02, 8'h00, 1'b1, 1'b0, 3'd6, 4'd4},  // R4 fetch refused
    '{2'd0, 8'h91, 8'h00, 1'b0, 1'b1, 3'd1, 4'd3},  // R3 restart ch1
    '{2'd3, 8'h00, 8'h00, 1'b0, 1'b1, 3'd1, 4'd3},  // R3 start disarmed
    '{2'd0, 8'h02, 8'h00, 1'b0, 1'b1, 3'd1, 4'd4},  // R4
    '{2'd3, 8'h00, 8'hFF, 1'b0, 1'b1, 3'd1, 4'd7},  // R7 fresh high byte
    '{2'd3, 8'h00, 8'h80, 1'b0, 1'b1, 3'd1, 4'd6}   // R6
  };

  logic [7:0] got;
  logic       oe_seen;
  bit         timed_out;

  task automatic xfer(input logic [1:0] op, input logic [7:0] b);
    int t;
    @(negedge clk);
    dir_to_host = op[0];
    bus_i = b;
    if (op[1]) dstb_n = 1'b0; else astb_n = 1'b0;
    t = 0;
    timed_out = 0;
    @(negedge clk);
    while (!wait_o && t < 50) begin @(negedge clk); t++; end
    if (!wait_o) timed_out = 1;
    got = bus_o;
    oe_seen = bus_oe;
    astb_n = 1'b1;
    dstb_n = 1'b1;
    @(negedge clk);
    while (wait_o && t < 100) begin @(negedge clk); t++; end
  endtask

  initial begin
    fmem[0] = 16'hA1B2; fmem[1] = 16'hC3D4; fmem[2] = 16'h0F0E;
    fmem[3] = 16'hFF80; fmem[4] = 16'h5A6B; fmem[5] = 16'h0;
    fmem[6] = 16'h0;    fmem[7] = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12", "adc_hold", adc_hold, 1);
    chk("R12", "wait_o", wait_o, 0);
    chk("R12", "bus_oe", bus_oe, 0);
    chk("R12", "fifo_rd", fifo_rd, 0);
    chk("R12", "mux_chan", mux_chan, 0);
    chk("R12", "mux_override", mux_override, 0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[i].rq);
      xfer(VECS[i].op, VECS[i].din);
      chk(rq, "wait completed", timed_out, 0);
      if (VECS[i].op[0]) begin
        chk(rq, "read byte", got, VECS[i].exp);
        chk("R10", "oe on read", oe_seen, 1);
      end else begin
        chk("R10", "oe on write", oe_seen, 0);
      end
      chk(rq, "adc_hold", adc_hold, VECS[i].hold);
      chk(rq, "mux_override", mux_override, VECS[i].ovr);
      chk(rq, "mux_chan", mux_chan, VECS[i].chan);
    end
    // R6 R8 exactly four words popped over the walk
    chk("R6", "pop count", rd_idx, 4);

    // R1 unknown code 7 changes nothing
    xfer(2'd0, 8'hF7);
    chk("R1", "chan after unknown code", mux_chan, 1);
    chk("R1", "ovr after unknown code", mux_override, 1);
    chk("R1", "hold after unknown code", adc_hold, 0);

    // R11 stall on empty FIFO, then R9/R10 handshake detail
    @(negedge clk);
    dir_to_host = 1'b1;
    dstb_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R11", "wait while empty", wait_o, 0);
    chk("R11", "no pop while empty", rd_idx, 4);
    avail = 5;
    @(negedge clk);
    chk("R9", "wait after service edge", wait_o, 1);
    chk("R11", "byte after stall", bus_o, 8'h5A);
    chk("R11", "one pop after stall", rd_idx, 5);
    repeat (3) @(negedge clk);
    chk("R9", "wait held while strobe low", wait_o, 1);
    dir_to_host = 1'b0;
    #1;
    chk("R10", "oe drops with direction", bus_oe, 0);
    @(negedge clk);
    dir_to_host = 1'b1;
    #1;
    chk("R10", "oe back with direction", bus_oe, 1);
    dstb_n = 1'b1;
    @(negedge clk);
    chk("R9", "wait released", wait_o, 0);
    chk("R10", "oe released", bus_oe, 0);
    xfer(2'd3, 8'h00);
    chk("R6", "low byte after stall", got, 8'h6B);
    chk("R6", "no pop for low byte", rd_idx, 5);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule